// File: doc/BRIEF.md
# Externally clocked serial transmitter with holding buffer

This block sends parallel words out on a single data line, one bit per cycle of a shift clock that arrives from outside the block. It never makes a shift clock of its own. A host writes words into a holding register; from there each word is handed to a shift register, which drives the data line least significant bit first. The two registers let the host queue one word while the previous one is still on the line.

The external clock is brought into the system clock domain through a synchronizer. A polarity control selects which of its edges counts as the active one. The data line changes on the inactive edge, so a receiver can sample it on the next active edge. Each word is either 8 data bits or, in nine-bit mode, the data bits followed by an extra bit supplied with the write. A transmit flag tells the host when the holding register can take a new word, and a maskable interrupt output follows that flag. Clearing the transmit enable aborts all activity and returns the line to idle.

Top module: `sst_tx`

## Requirements
- R1: A write (`wr_en` high for one clock) is accepted only while `port_en`, `sync_mode` and `tx_en` are all 1 and `clk_master` is 0. Otherwise the write is dropped and `shift_empty` stays 1.
- R2: A word accepted while both registers are empty reaches the shift register on the second rising clock edge after the write. At that point `shift_empty` goes to 0, `tx_flag` reads 1, and `ser_dout` shows data bit 0.
- R3: A word accepted while the shift register is busy waits in the holding register. `tx_flag` reads 0 for as long as it waits, and a further write while the holding register is full is dropped.
- R4: When the last bit of the current word has gone out, a waiting word moves into the shift register and `tx_flag` returns to 1.
- R5: Bits leave least significant bit first. The line advances to the next bit only on a falling edge of the effective clock, so each bit is stable across a rising edge of the effective clock.
- R6: The effective clock is `ext_clk` when `clk_invert` is 0 and its complement when `clk_invert` is 1.
- R7: When `nine_bit_en` is 1 at the time of the write, the frame has nine bits. The ninth bit, taken from `ninth_bit` at the same write, goes out after data bit 7. Otherwise the frame has 8 bits.
- R8: `irq` is 1 exactly when `tx_flag` and `irq_en` are both 1.
- R9: `shift_empty` is 1 whenever no word is being shifted, and `ser_dout` is 1 in that state.
- R10: When the enable condition of R1 drops, the next clock aborts the shift and discards any held word. `ser_dout` goes to 1, and `shift_empty` and `tx_flag` go to 1.
- R11: After reset, `shift_empty`, `tx_flag` and `ser_dout` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select, must be 1 |
| clk_master | input | 1 | Clock source select, must be 0 (external clock) |
| tx_en | input | 1 | Transmit enable; clearing it aborts |
| nine_bit_en | input | 1 | Nine-bit frame mode |
| clk_invert | input | 1 | Invert the external clock |
| ninth_bit | input | 1 | Ninth bit captured with each write |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to transmit |
| ext_clk | input | 1 | External shift clock |
| ser_dout | output | 1 | Serial data line, idle high |
| shift_empty | output | 1 | Shift register holds no word |
| tx_flag | output | 1 | Holding register can accept a word |
| irq | output | 1 | Masked transmit interrupt |

## Verification
The bench builds the block with its defaults: DATA_W of 8 and two synchronizer stages. At that size every 8-bit data value can be sent once, with the clock polarity alternating from word to word. A sweep of 64 values times both ninth-bit settings covers nine-bit framing. A shift-clock phase of six system clocks leaves room for the synchronizer and edge-detect delay, so each frame can be rebuilt bit by bit at the pins. Directed sequences cover the queued handoff, a dropped third write, an abort with a word held, and each gating input.

// File: rtl/sst_pkg.sv
package sst_pkg;
    // number of bits in one frame for a given data width and mode
    function automatic int unsigned frame_len(input int unsigned data_w, input logic nine);
        return nine ? data_w + 1 : data_w;
    endfunction
endpackage

// File: rtl/sst_clk_sync.sv
module sst_clk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic invert,
    output logic fall_edge
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;
    logic  eff;

    assign eff = s_q.chain[STAGES-1] ^ invert;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                s_d          = s_q;
                s_d.chain[0] = ext_clk;
                s_d.prev     = eff;
            end
        end else begin : g_multi
            always_comb begin
                s_d       = s_q;
                s_d.chain = {s_q.chain[STAGES-2:0], ext_clk};
                s_d.prev  = eff;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fall_edge = s_q.prev & ~eff;
endmodule

// File: rtl/sst_shift.sv
module sst_shift #(
    parameter int unsigned DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            load,
    input  logic [DATA_W:0] load_frame,
    input  logic            load_nine,
    input  logic            adv,
    output logic            busy,
    output logic            last,
    output logic            dout
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 2);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [DATA_W:0]  sh;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d = '0;
        end else if (load) begin
            s_d.busy = 1'b1;
            s_d.sh   = load_frame;
            s_d.cnt  = CNT_W'(sst_pkg::frame_len(DATA_W, load_nine));
        end else if (adv && s_q.busy) begin
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.sh  = {1'b0, s_q.sh[DATA_W:1]};
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign last = s_q.busy && (s_q.cnt == CNT_W'(1));
    assign dout = s_q.busy ? s_q.sh[0] : 1'b1;
endmodule

// File: rtl/sst_tx.sv
module sst_tx #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              clk_master,
    input  logic              tx_en,
    input  logic              nine_bit_en,
    input  logic              clk_invert,
    input  logic              ninth_bit,
    input  logic              irq_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_clk,
    output logic              ser_dout,
    output logic              shift_empty,
    output logic              tx_flag,
    output logic              irq
);
    typedef struct packed {
        logic            hold_valid;
        logic [DATA_W:0] hold_frame;
        logic            hold_nine;
        logic            flag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic run, fall, sh_busy, sh_last, sh_load, wr_take, done;
    logic hold_full;

    assign run = port_en & sync_mode & ~clk_master & tx_en;

    sst_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk   (ext_clk),
        .invert    (clk_invert),
        .fall_edge (fall)
    );

    assign done    = fall & sh_last;
    assign sh_load = run & ctl_q.hold_valid & (~sh_busy | done);
    assign wr_take = run & wr_en & ~ctl_q.hold_valid;

    sst_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (~run),
        .load       (sh_load),
        .load_frame (ctl_q.hold_frame),
        .load_nine  (ctl_q.hold_nine),
        .adv        (fall),
        .busy       (sh_busy),
        .last       (sh_last),
        .dout       (ser_dout)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!run) begin
            ctl_d.hold_valid = 1'b0;
            ctl_d.flag       = 1'b1;
        end else if (sh_load) begin
            ctl_d.hold_valid = 1'b0;
            ctl_d.flag       = 1'b1;
        end else if (wr_take) begin
            ctl_d.hold_valid = 1'b1;
            ctl_d.hold_frame = {ninth_bit, wr_data};
            ctl_d.hold_nine  = nine_bit_en;
            ctl_d.flag       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.flag <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign hold_full   = ctl_q.hold_valid;
    assign shift_empty = ~sh_busy;
    assign tx_flag     = ctl_q.flag;
    assign irq         = ctl_q.flag & irq_en;
endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic sync_mode,
    input logic clk_master,
    input logic tx_en,
    input logic irq_en,
    input logic hold_full,
    input logic ser_dout,
    input logic shift_empty,
    input logic tx_flag,
    input logic irq
);
    logic en_all;
    assign en_all = port_en & sync_mode & ~clk_master & tx_en;

    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_all |=> (ser_dout && shift_empty && tx_flag));

    a_r3_flag_low_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        hold_full |-> !tx_flag);

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    a_r9_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> ser_dout);

    a_r2_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all && hold_full && shift_empty) |=> (!shift_empty && tx_flag));
endmodule

bind sst_tx sst_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_en     (port_en),
    .sync_mode   (sync_mode),
    .clk_master  (clk_master),
    .tx_en       (tx_en),
    .irq_en      (irq_en),
    .hold_full   (hold_full),
    .ser_dout    (ser_dout),
    .shift_empty (shift_empty),
    .tx_flag     (tx_flag),
    .irq         (irq)
);

// File: tb/tb_sst_tx.sv
module tb_sst_tx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b1, sync_mode = 1'b1, clk_master = 1'b0, tx_en = 1'b1;
    logic       nine_bit_en = 1'b0, clk_invert = 1'b0, ninth_bit = 1'b0, irq_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ext_clk = 1'b0;
    logic       ser_dout, shift_empty, tx_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sst_tx dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
        .clk_master(clk_master), .tx_en(tx_en), .nine_bit_en(nine_bit_en),
        .clk_invert(clk_invert), .ninth_bit(ninth_bit), .irq_en(irq_en),
        .wr_en(wr_en), .wr_data(wr_data), .ext_clk(ext_clk),
        .ser_dout(ser_dout), .shift_empty(shift_empty), .tx_flag(tx_flag), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // effective clock level drive (R6)
    task automatic set_eff(input logic lvl);
        ext_clk = lvl ^ clk_invert;
    endtask

    task automatic write_word(input logic [7:0] d, input logic nb);
        wr_data = d; ninth_bit = nb; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
    endtask

    // receive nbits: sample, active edge, inactive edge
    task automatic recv(input int nbits, output logic [8:0] frame);
        frame = '0;
        for (int i = 0; i < nbits; i++) begin
            frame[i] = ser_dout;
            set_eff(1'b1); tick(HALF_BIT);
            check(ser_dout == frame[i], "R5", ser_dout, frame[i]);
            set_eff(1'b0); tick(HALF_BIT);
        end
    endtask

    initial begin
        logic [8:0] got;
        logic [8:0] exp9;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R11 reset state
        check(shift_empty == 1'b1, "R11", shift_empty, 1);
        check(tx_flag == 1'b1, "R11", tx_flag, 1);
        check(ser_dout == 1'b1, "R11", ser_dout, 1);
        check(irq == 1'b0, "R8", irq, 0);
        irq_en = 1'b1; tick(1);
        check(irq == 1'b1, "R8", irq, 1);
        irq_en = 1'b0;

        // R1/R5/R6 sweep of all 8-bit values, alternating polarity
        for (int v = 0; v < 256; v++) begin
            clk_invert = v[0];
            set_eff(1'b0);
            tick(HALF_BIT);
            write_word(8'(v), 1'b0);
            tick(1);
            if (v < 4) begin
                check(shift_empty == 1'b0, "R2", shift_empty, 0);
                check(tx_flag == 1'b1, "R2", tx_flag, 1);
            end
            recv(8, got);
            check(got[7:0] == 8'(v), v[0] ? "R6" : "R5", got[7:0], v);
            tick(2);
            check(shift_empty == 1'b1 && ser_dout == 1'b1, "R9", {shift_empty, ser_dout}, 3);
        end
        clk_invert = 1'b0; set_eff(1'b0); tick(HALF_BIT);

        // R7 nine-bit sweep
        nine_bit_en = 1'b1;
        for (int v = 0; v < 128; v++) begin
            exp9 = {v[0], 8'(v * 37 + 5)};
            write_word(exp9[7:0], exp9[8]);
            tick(1);
            recv(9, got);
            check(got == exp9, "R7", got, exp9);
            tick(2);
        end
        nine_bit_en = 1'b0;

        // R3/R4 queued handoff and dropped third write
        write_word(8'hA5, 1'b0);
        tick(1);
        write_word(8'h3C, 1'b0);
        check(tx_flag == 1'b0, "R3", tx_flag, 0);
        irq_en = 1'b1; tick(1);
        check(irq == 1'b0, "R8", irq, 0);
        write_word(8'hFF, 1'b0);
        check(tx_flag == 1'b0, "R3", tx_flag, 0);
        recv(8, got);
        check(got[7:0] == 8'hA5, "R4", got[7:0], 8'hA5);
        check(tx_flag == 1'b1 && shift_empty == 1'b0, "R4", {tx_flag, shift_empty}, 2);
        check(irq == 1'b1, "R8", irq, 1);
        irq_en = 1'b0;
        recv(8, got);
        check(got[7:0] == 8'h3C, "R4", got[7:0], 8'h3C);
        tick(2);
        check(shift_empty == 1'b1, "R3", shift_empty, 1);

        // R10 abort with a held word
        write_word(8'h81, 1'b0);
        tick(1);
        write_word(8'h42, 1'b0);
        set_eff(1'b1); tick(HALF_BIT); set_eff(1'b0); tick(HALF_BIT);
        tx_en = 1'b0;
        tick(1);
        check(ser_dout == 1'b1 && shift_empty == 1'b1 && tx_flag == 1'b1, "R10",
              {ser_dout, shift_empty, tx_flag}, 7);
        tx_en = 1'b1;
        tick(4);
        check(shift_empty == 1'b1, "R10", shift_empty, 1);
        write_word(8'h6E, 1'b0);
        tick(1);
        recv(8, got);
        check(got[7:0] == 8'h6E, "R10", got[7:0], 8'h6E);
        tick(2);

        // R1 gating inputs
        for (int g = 0; g < 4; g++) begin
            port_en = (g != 0); sync_mode = (g != 1); clk_master = (g == 2); tx_en = (g != 3);
            tick(1);
            write_word(8'h55, 1'b0);
            tick(3);
            check(shift_empty == 1'b1 && ser_dout == 1'b1, "R1", {shift_empty, ser_dout}, 3);
            port_en = 1'b1; sync_mode = 1'b1; clk_master = 1'b0; tx_en = 1'b1;
            tick(3);
            check(shift_empty == 1'b1, "R1", shift_empty, 1);
        end

        done_run = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_run) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule